// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block divides its clock by a programmed ratio N between 3 and 15,999. It produces a pulse on `div_out` that is high for exactly one clock and repeats every N clocks. The count is held in three parts. A fast first section has a modulus chosen by a 3-bit mode code. It is followed by three BCD decades, and then by a small last section. The last section is built from the bits of the low jam nibble that the chosen first-section modulus leaves free. Every time the first section wraps, the value held in the decades and the last section drops by one.

A 16-bit jam word presets all sections. The jam value is loaded when the master preset is raised, and it is loaded again automatically at the end of every period, so the period stays exactly N. When latching is enabled, the first pulse after a preset is held high until the next preset. All behaviour is synchronous to the single clock and fully static, so the clock may be stopped at any point.

Top module: `prog_freq_divider`

## Requirements
- R1: While `rst_n` is low, the counter clears on the clock edge and `div_out` is 0. After reset, the counter stays idle with `div_out` low until the first master preset, whatever the jam and mode inputs are.
- R2: The ratio is N = m·(1000·L + 100·D3 + 10·D2 + D1) + F. The terms are:
  - m is the first-section modulus.
  - F is `jam_val` bits [w-1:0], where w is the first-section width.
  - L is `jam_val` bits [3:w], and is 0 when w = 4.
  - D1 is bits [7:4], D2 is bits [11:8] and D3 is bits [15:12].

  `div_out` is high for exactly one clock in every N clocks.
- R3: `mode_sel` selects m and w. The codes are 000 → m=2, w=1; 001 → m=4, w=2; 010 → m=5, w=3; 011 → m=8, w=3; 100 → m=10, w=4. Codes 101, 110 and 111 behave as 100.
- R4: An F greater than m−1 is taken as m−1. A decade nibble above 9 is taken as 9.
- R5: A jam value that yields N below 3 is loaded as N = 3.
- R6: With latching off, the first pulse after a master preset is high in the cycle that follows the (N−1)th rising edge after the edge that sampled the preset.
- R7: With `latch_en` high, once a pulse occurs, `div_out` stays high until a clock edge samples `master_preset` high. That edge clears it.
- R8: Both `jam_val` and `mode_sel` are sampled again at every end-of-period reload. A change made in the middle of a count takes effect from the next period.
- R9: The largest N is 15,999 in the m=2, 4 and 8 modes and 9,999 in the m=5 and 10 modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| jam_val | input | 16 | Preset value for all counting sections |
| mode_sel | input | 3 | First-section modulus code |
| master_preset | input | 1 | Synchronous load of the jam value |
| latch_en | input | 1 | Hold the output high after the first pulse |
| div_out | output | 1 | Divided pulse output |

## Verification
`div_out` is decoded directly from the counter state, with no output register. As a result, the first pulse is visible in the cycle after the (N−1)th rising edge that follows the preset edge, and each later pulse comes N edges after the one before it. A latched level becomes visible one edge after the pulse that set it, and it is cleared by the edge that samples the preset.

The bench drives inputs and compares outputs on the falling edge. It steps a reference value through the same edges, so every check falls half a cycle after the edge that caused it. Pulse spacing is measured in counted edges, from the preset edge to the first pulse and then from pulse to pulse.

// File: rtl/pfd_pkg.sv
// Shared constants and mode decoding for the programmable frequency divider.
// Assumes BCD decades of four bits and a four-bit first-section field.
package pfd_pkg;

    localparam int DIG_W    = 4;
    localparam int LAST_W   = 3;

    localparam logic [2:0] MODE_DIV2  = 3'b000;
    localparam logic [2:0] MODE_DIV4  = 3'b001;
    localparam logic [2:0] MODE_DIV5  = 3'b010;
    localparam logic [2:0] MODE_DIV8  = 3'b011;
    localparam logic [2:0] MODE_DIV10 = 3'b100;

    // Modulus of the first section and how many low jam bits it occupies
    typedef struct packed {
        logic [3:0] modulus;
        logic [2:0] width;
    } sect_cfg_t;

    // Map a mode code to its first-section configuration (unlisted codes act as divide-by-10)
    function automatic sect_cfg_t decode_mode(input logic [2:0] code);
        sect_cfg_t cfg;
        case (code)
            MODE_DIV2: cfg = '{modulus: 4'd2,  width: 3'd1};
            MODE_DIV4: cfg = '{modulus: 4'd4,  width: 3'd2};
            MODE_DIV5: cfg = '{modulus: 4'd5,  width: 3'd3};
            MODE_DIV8: cfg = '{modulus: 4'd8,  width: 3'd3};
            default:   cfg = '{modulus: 4'd10, width: 3'd4};
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/pfd_load_calc.sv
// Load value calculation.
// Splits the jam word into first-section, decade and last-section load values
// for the selected mode, clamps out-of-range fields and raises ratios below 3.
// Assumes the low jam nibble is shared by the first and last sections.
module pfd_load_calc
    import pfd_pkg::*;
#(
    parameter int NUM_DEC = 3
) (
    input  logic [DIG_W*(NUM_DEC+1)-1:0]   jam,
    input  logic [2:0]                     mode,
    output logic [3:0]                     first_ld,
    output logic [3:0]                     modulus_ld,
    output logic [NUM_DEC-1:0][DIG_W-1:0]  dig_ld,
    output logic [LAST_W-1:0]              last_ld
);

    localparam logic [NUM_DEC*DIG_W-1:0] DIG_ONE = (NUM_DEC*DIG_W)'(1);

    sect_cfg_t                     cfg;
    logic [3:0]                    first_mask;
    logic [3:0]                    first_raw;
    logic [3:0]                    first_max;
    logic [3:0]                    first_c;
    logic [LAST_W-1:0]             last_raw;
    logic [NUM_DEC-1:0][DIG_W-1:0] dig_c;
    logic                          upper_zero;
    logic                          upper_one;
    logic                          too_small;

    // Clamp each decade nibble into BCD range
    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dig_clamp
        always_comb begin
            if (jam[DIG_W*(g+1) +: DIG_W] > 4'd9) begin
                dig_c[g] = 4'd9;
            end else begin
                dig_c[g] = jam[DIG_W*(g+1) +: DIG_W];
            end
        end
    end

    // Split the shared low nibble between first and last sections
    always_comb begin
        cfg        = decode_mode(mode);
        first_mask = 4'((5'd1 << cfg.width) - 5'd1);
        first_raw  = jam[3:0] & first_mask;
        first_max  = cfg.modulus - 4'd1;
        first_c    = (first_raw > first_max) ? first_max : first_raw;
        last_raw   = LAST_W'(jam[3:0] >> cfg.width);
    end

    // Detect ratios below three and substitute the value three
    always_comb begin
        upper_zero = (dig_c == '0) && (last_raw == '0);
        upper_one  = (dig_c == DIG_ONE) && (last_raw == '0);
        too_small  = (upper_zero && (first_c < 4'd3)) ||
                     ((cfg.modulus == 4'd2) && upper_one && (first_c == 4'd0));
        modulus_ld = cfg.modulus;
        if (too_small) begin
            last_ld = '0;
            if (cfg.modulus == 4'd2) begin
                first_ld = 4'd1;
                dig_ld   = DIG_ONE;
            end else begin
                first_ld = 4'd3;
                dig_ld   = '0;
            end
        end else begin
            first_ld = first_c;
            dig_ld   = dig_c;
            last_ld  = last_raw;
        end
    end

endmodule

// File: rtl/pfd_first_stage.sv
// Fast first counting section.
// A down-counter whose modulus is captured at every load. It wraps from 0 to
// modulus-1 and signals a borrow on the wrapping step.
// Assumes the load value is already below the modulus.
module pfd_first_stage #(
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dec_en,
    input  logic [SECT_W-1:0] ld_val,
    input  logic [SECT_W-1:0] ld_mod,
    output logic [SECT_W-1:0] val,
    output logic [SECT_W-1:0] modulus,
    output logic              borrow
);

    // Hold the count and the modulus it runs under
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val     <= '0;
            modulus <= SECT_W'(10);
        end else if (load) begin
            val     <= ld_val;
            modulus <= ld_mod;
        end else if (dec_en) begin
            val <= (val == '0) ? modulus - SECT_W'(1) : val - SECT_W'(1);
        end
    end

    // Borrow into the next section on the wrap step
    assign borrow = dec_en && (val == '0);

endmodule

// File: rtl/pfd_down_digit.sv
// Generic loadable down-counting digit.
// Used both for the BCD decades (wrap to 9) and for the last section.
// Assumes the caller only steps it when a borrow arrives from below.
module pfd_down_digit #(
    parameter int         W    = 4,
    parameter logic [W-1:0] WRAP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         bin,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val
);

    // Load, or step down by one on a borrow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= ld_val;
        end else if (bin) begin
            val <= (val == '0) ? WRAP : val - W'(1);
        end
    end

endmodule

// File: rtl/prog_freq_divider.sv
// Programmable divide-by-N counter, top level.
// Chains the first section, NUM_DEC BCD decades and the last section. It
// reloads from the jam inputs on master preset or at terminal count (value 1),
// and drives a one-cycle pulse that can be held until the next preset.
// Assumes all inputs are synchronous to clk.
module prog_freq_divider
    import pfd_pkg::*;
#(
    parameter int NUM_DEC = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DIG_W*(NUM_DEC+1)-1:0] jam_val,
    input  logic [2:0]                   mode_sel,
    input  logic                         master_preset,
    input  logic                         latch_en,
    output logic                         div_out
);

    logic [3:0]                    first_ld;
    logic [3:0]                    modulus_ld;
    logic [NUM_DEC-1:0][DIG_W-1:0] dig_ld;
    logic [LAST_W-1:0]             last_ld;
    logic [3:0]                    first_val;
    logic [3:0]                    modulus;
    logic [NUM_DEC-1:0][DIG_W-1:0] dig_val;
    logic [LAST_W-1:0]             last_val;
    logic [NUM_DEC:0]              chain;
    logic                          first_borrow;
    logic                          upper_zero;
    logic                          tc;
    logic                          idle;
    logic                          load;
    logic                          dec_en;
    logic                          latched;

    pfd_load_calc #(.NUM_DEC(NUM_DEC)) load_i (
        .jam        (jam_val),
        .mode       (mode_sel),
        .first_ld   (first_ld),
        .modulus_ld (modulus_ld),
        .dig_ld     (dig_ld),
        .last_ld    (last_ld)
    );

    pfd_first_stage #(.SECT_W(4)) first_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .dec_en  (dec_en),
        .ld_val  (first_ld),
        .ld_mod  (modulus_ld),
        .val     (first_val),
        .modulus (modulus),
        .borrow  (first_borrow)
    );

    assign chain[0] = first_borrow;

    // One BCD decade per position, each borrowing from the one below
    for (genvar g = 0; g < NUM_DEC; g++) begin : g_decade
        pfd_down_digit #(.W(DIG_W), .WRAP(4'd9)) dec_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .bin    (chain[g]),
            .ld_val (dig_ld[g]),
            .val    (dig_val[g])
        );
        assign chain[g+1] = chain[g] && (dig_val[g] == '0);
    end

    pfd_down_digit #(.W(LAST_W), .WRAP('1)) last_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .bin    (chain[NUM_DEC]),
        .ld_val (last_ld),
        .val    (last_val)
    );

    // Terminal and idle decoding of the whole mixed-radix value
    always_comb begin
        upper_zero = (dig_val == '0) && (last_val == '0);
        tc         = upper_zero && (first_val == 4'd1);
        idle       = upper_zero && (first_val == 4'd0);
        load       = master_preset || tc;
        dec_en     = !load && !idle;
    end

    // Hold the output after a pulse when latching is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
        end else if (master_preset) begin
            latched <= 1'b0;
        end else if (tc && latch_en) begin
            latched <= 1'b1;
        end
    end

    assign div_out = tc || latched;

endmodule

// File: rtl/pfd_checker.sv
// Assertion checker for the programmable frequency divider, bound to the top.
// Observes the terminal, idle and latch state plus the first-section range.
module pfd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       master_preset,
    input logic       latch_en,
    input logic       div_out,
    input logic       tc,
    input logic       idle,
    input logic       latched,
    input logic [3:0] first_val,
    input logic [3:0] modulus
);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !master_preset) |=> (idle && !div_out));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    assert_first_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        first_val < modulus);

    assert_load_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        master_preset |=> (!tc && !idle));

    assert_latch_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && latch_en && !master_preset) |=> div_out);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !master_preset) |=> div_out);

endmodule

bind prog_freq_divider pfd_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .master_preset (master_preset),
    .latch_en      (latch_en),
    .div_out       (div_out),
    .tc            (tc),
    .idle          (idle),
    .latched       (latched),
    .first_val     (first_val),
    .modulus       (modulus)
);

// File: tb/prog_freq_divider_tb_top.sv
// Self-checking bench: random and directed jam/mode patterns, a per-cycle
// reference value and pulse-spacing measurement.
module prog_freq_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] jam;
    logic [2:0]  mode;
    logic        preset;
    logic        latch_en;
    logic        q;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    wd = 0;
    int    exp_v = 0;
    bit    exp_lat = 1'b0;
    int    exp_n = 0;
    int    last_evt = 0;
    bit    first_pend = 1'b0;
    bit    meas_on = 1'b0;
    string cur_tag = "R1";
    string ptag = "R2";

    always #5 clk = ~clk;

    prog_freq_divider dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .jam_val       (jam),
        .mode_sel      (mode),
        .master_preset (preset),
        .latch_en      (latch_en),
        .div_out       (q)
    );

    // Modulus chosen by each mode code
    function automatic int mod_of(input logic [2:0] m);
        case (m)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 5;
            3'd3: return 8;
            default: return 10;
        endcase
    endfunction

    // Number of low jam bits held by the first section
    function automatic int wid_of(input logic [2:0] m);
        case (m)
            3'd0: return 1;
            3'd1: return 2;
            3'd2, 3'd3: return 3;
            default: return 4;
        endcase
    endfunction

    // Expected ratio N from the requirement formula
    function automatic int load_n(input logic [15:0] j, input logic [2:0] m);
        int md = mod_of(m);
        int w  = wid_of(m);
        int f  = int'(j[3:0]) % (1 << w);
        int l  = int'(j[3:0]) >> w;
        int d1 = (j[7:4]   > 9) ? 9 : int'(j[7:4]);
        int d2 = (j[11:8]  > 9) ? 9 : int'(j[11:8]);
        int d3 = (j[15:12] > 9) ? 9 : int'(j[15:12]);
        int n;
        if (f > md - 1) f = md - 1;
        n = md * (l * 1000 + d3 * 100 + d2 * 10 + d1) + f;
        return (n < 3) ? 3 : n;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // One clock: step the reference at the edge, compare at the falling edge
    task automatic tick();
        bit was_preset;
        bit exp_q;
        @(posedge clk);
        was_preset = preset;
        if (!rst_n) begin
            exp_v = 0; exp_lat = 1'b0;
        end else if (preset) begin
            exp_v = load_n(jam, mode); exp_lat = 1'b0;
        end else begin
            if (exp_v == 1 && latch_en) exp_lat = 1'b1;
            if (exp_v == 1) exp_v = load_n(jam, mode);
            else if (exp_v != 0) exp_v--;
        end
        cyc++;
        @(negedge clk);
        exp_q = (exp_v == 1) || exp_lat;
        chk(q == exp_q, cur_tag, int'(q), int'(exp_q));
        if (was_preset) begin
            last_evt = cyc; first_pend = 1'b1;
        end
        if (q && !latch_en && meas_on) begin
            if (first_pend) chk(cyc - last_evt == exp_n - 1, "R6", cyc - last_evt, exp_n - 1);
            else            chk(cyc - last_evt == exp_n, ptag, cyc - last_evt, exp_n);
            first_pend = 1'b0;
            last_evt   = cyc;
        end
    endtask

    // Preset a ratio and run for a number of cycles while measuring pulses
    task automatic run_div(input logic [15:0] j, input logic [2:0] m, input int ticks, input string tag);
        jam = j; mode = m; preset = 1'b1;
        cur_tag = tag; ptag = tag;
        exp_n = load_n(j, m);
        meas_on = 1'b1;
        tick();
        preset = 1'b0;
        repeat (ticks) tick();
        meas_on = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", wd, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4059);
        rst_n = 1'b0; jam = 16'h0000; mode = 3'd0; preset = 1'b0; latch_en = 1'b0;
        repeat (3) tick();
        chk(q == 1'b0, "R1", int'(q), 0);
        rst_n = 1'b1;
        // R1: idle without preset whatever the inputs
        cur_tag = "R1";
        jam = 16'h1234; mode = 3'd3;
        repeat (20) tick();
        chk(q == 1'b0, "R1", int'(q), 0);

        // R2 R3: random small ratios in every mode code, two periods each
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 2; r++) begin
                int w = wid_of(3'(m));
                logic [15:0] j;
                j = {4'h0, 4'($urandom % 3), 4'($urandom % 10), 4'($urandom % (1 << w))};
                run_div(j, 3'(m), 2 * load_n(j, 3'(m)) + 4, (m > 4) ? "R3" : "R2");
            end
        end

        // R4: out-of-range first field and decade nibble
        chk(load_n(16'h00C7, 3'd2) == 49, "R4", load_n(16'h00C7, 3'd2), 49);
        run_div(16'h00C7, 3'd2, 2 * 49 + 4, "R4");
        run_div(16'h003F, 3'd4, 2 * 39 + 4, "R4");

        // R5: ratios below three become three
        run_div(16'h0000, 3'd4, 12, "R5");
        run_div(16'h0001, 3'd0, 12, "R5");
        run_div(16'h0010, 3'd0, 12, "R5");
        run_div(16'h0002, 3'd1, 12, "R5");

        // R6: preset in mid-count restarts the count
        run_div(16'h0025, 3'd1, 30, "R6");
        run_div(16'h0013, 3'd3, 60, "R6");

        // R7: latched output held until the next preset
        latch_en = 1'b1;
        run_div(16'h0007, 3'd4, 30, "R7");
        chk(q == 1'b1, "R7", int'(q), 1);
        preset = 1'b1;
        tick();
        preset = 1'b0;
        chk(q == 1'b0, "R7", int'(q), 0);
        repeat (12) tick();
        latch_en = 1'b0;
        repeat (3) tick();

        // R8: jam and mode changed mid-count apply from the next period
        run_div(16'h0012, 3'd4, 5, "R8");
        jam = 16'h0030; mode = 3'd0;
        cur_tag = "R8";
        repeat (60) tick();
        chk(load_n(16'h0030, 3'd0) == 6, "R8", load_n(16'h0030, 3'd0), 6);
        jam = 16'h0004; mode = 3'd2;
        repeat (30) tick();

        // R9: largest ratio in every mode
        run_div(16'h999F, 3'd0, 2 * 15999 + 4, "R9");
        run_div(16'h999F, 3'd1, 15999 + 4, "R9");
        run_div(16'h999F, 3'd3, 15999 + 4, "R9");
        run_div(16'h999F, 3'd2, 9999 + 4, "R9");
        run_div(16'h999F, 3'd4, 9999 + 4, "R9");
        chk(load_n(16'h999F, 3'd0) == 15999, "R9", load_n(16'h999F, 3'd0), 15999);
        chk(load_n(16'h999F, 3'd4) == 9999, "R9", load_n(16'h999F, 3'd4), 9999);

        // R1: reset in mid-count returns to idle
        rst_n = 1'b0;
        cur_tag = "R1";
        tick();
        rst_n = 1'b1;
        chk(q == 1'b0, "R1", int'(q), 0);
        repeat (10) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule